// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block guards a battery-backed static memory array against corruption while the main supply is unreliable. Three comparator outputs report whether the supply is above the full-function level, above the lower switchover level, and above the one-time arming level. The block synchronizes each flag and rejects short glitches. It then moves through a small set of power states, and in every state except the normal one it holds the memory strobes off and the data-output enable low.

The backup cell is never connected until the supply has once crossed the arming level. From then on the arming latch stays set until reset, and reset here stands for factory assembly. When the supply falls below the switchover level, the array is moved onto the backup cell. When the supply comes back above that level, the array returns to the main rail. Host access is honoured again only after the supply is back at the full-function level and the host chip-enable has stayed inactive for a whole recovery interval.

The host lines act as plain synchronous control pins. They pass straight through to the array while the block is in the normal state, and the block has no handshake on them.

Top module: `pfs_supervisor`

## Requirements
- R1: Each supply flag passes through two synchronizing flops. The filtered value takes a new level only after the synchronized flag has differed from it on STABLE_CYC consecutive clocks. A shorter pulse has no effect on the status.
- R2: After reset, status is 0 (unarmed), batt_armed is 0 and sel_backup is 0. mem_ce_n and mem_we_n are 1 and dq_oe is 0.
- R3: The block leaves the unarmed state only when the filtered arming flag is 1. It then moves to the protected state and sets batt_armed, which stays 1 until reset even if the arming flag later drops. Before arming, sel_backup stays 0 even with the switchover flag low.
- R4: Whenever status is not 1 (normal), mem_ce_n and mem_we_n are 1 and dq_oe is 0, whatever the host lines do.
- R5: In the normal state, a low filtered full-function flag moves the block to the protected state on the next edge. A write strobe that is active at that moment is dropped in the same cycle.
- R6: In the protected state, a low filtered switchover flag moves the block to the battery state (status 3). sel_backup is 1 in the battery state and only there. A low switchover flag takes priority over a high full-function flag.
- R7: In the battery state, a high filtered switchover flag returns the block to the protected state, which sets sel_backup to 0.
- R8: In the protected state, with the switchover flag high, a high full-function flag enters the recovery state (status 4). The block reaches the normal state only after REC_CYC consecutive recovery clocks with host_ce_n high. A low host_ce_n restarts the count. A low full-function flag sends the block back to the protected state.
- R9: In the normal state, mem_ce_n follows host_ce_n and mem_we_n equals host_we_n OR host_ce_n. dq_oe is 1 exactly when host_ce_n and host_oe_n are 0 and host_we_n is 1.
- R10: The status encoding is 0 unarmed, 1 normal, 2 protected, 3 battery and 4 recovery. The normal state can be entered only from the recovery state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (factory state) |
| sup_sw_i | input | 1 | Comparator: supply above switchover level |
| sup_full_i | input | 1 | Comparator: supply above full-function level |
| sup_arm_i | input | 1 | Comparator: supply above arming level |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the array |
| mem_we_n | output | 1 | Gated write strobe to the array |
| dq_oe | output | 1 | Data output driver enable, active high |
| sel_backup | output | 1 | 1: array supplied from backup cell |
| batt_armed | output | 1 | One-time battery arming latch |
| status | output | 3 | Current power state code |

## Verification
The bench builds the block with STABLE_CYC = 2 and REC_CYC = 6. With these values, a one-cycle comparator pulse falls just short of the filter length, so glitch rejection is exercised on both the arming flag and the full-function flag. The short recovery window allows a chip-enable restart in the middle of a count, a supply dip during recovery, and complete power-down and power-up sequences. With these values, each sequence takes only tens of cycles and runs against a behavioural model.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_UNARMED   = 3'd0,
    ST_NORMAL    = 3'd1,
    ST_PROTECTED = 3'd2,
    ST_BATTERY   = 3'd3,
    ST_RECOVERY  = 3'd4
  } pfs_state_e;

  localparam int NUM_FLAGS = 3;
  localparam int FL_SW     = 0;
  localparam int FL_FULL   = 1;
  localparam int FL_ARM    = 2;
endpackage

// File: rtl/pfs_flag_filter.sv
module pfs_flag_filter #(
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic          sync1_q, sync2_q;
  logic          flt_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      run_q <= '0;
    end else if (sync2_q != flt_q) begin
      if (run_q == LAST) begin
        flt_q <= sync2_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/pfs_power_fsm.sv
module pfs_power_fsm
  import pfs_pkg::*;
#(
  parameter int REC_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       f_sw,
  input  logic       f_full,
  input  logic       f_arm,
  input  logic       host_ce_n,
  output pfs_state_e state_o,
  output logic       armed_o
);
  localparam int RW = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;
  localparam logic [RW-1:0] REC_LAST = RW'(REC_CYC - 1);

  pfs_state_e    state_q, state_d;
  logic          armed_q;
  logic [RW-1:0] rec_q, rec_d;
  logic          rec_done;

  assign rec_done = host_ce_n && (rec_q == REC_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_UNARMED:   if (f_arm) state_d = ST_PROTECTED;
      ST_PROTECTED: begin
        if (!f_sw)       state_d = ST_BATTERY;
        else if (f_full) state_d = ST_RECOVERY;
      end
      ST_BATTERY:   if (f_sw) state_d = ST_PROTECTED;
      ST_RECOVERY: begin
        if (!f_full)       state_d = ST_PROTECTED;
        else if (rec_done) state_d = ST_NORMAL;
      end
      ST_NORMAL:    if (!f_full) state_d = ST_PROTECTED;
      default:      state_d = ST_UNARMED;
    endcase
  end

  always_comb begin
    rec_d = '0;
    if (state_q == ST_RECOVERY && f_full && host_ce_n && rec_q != REC_LAST)
      rec_d = rec_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UNARMED;
      armed_q <= 1'b0;
      rec_q   <= '0;
    end else begin
      state_q <= state_d;
      rec_q   <= rec_d;
      if (state_q == ST_UNARMED && f_arm) armed_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/pfs_access_gate.sv
module pfs_access_gate
  import pfs_pkg::*;
(
  input  pfs_state_e state_i,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  input  logic       host_oe_n,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       dq_oe,
  output logic       sel_backup
);
  logic open_q;

  assign open_q     = (state_i == ST_NORMAL);
  assign mem_ce_n   = !open_q || host_ce_n;
  assign mem_we_n   = !open_q || host_ce_n || host_we_n;
  assign dq_oe      = open_q && !host_ce_n && !host_oe_n && host_we_n;
  assign sel_backup = (state_i == ST_BATTERY);
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
  import pfs_pkg::*;
#(
  parameter int STABLE_CYC = 4,
  parameter int REC_CYC    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_sw_i,
  input  logic       sup_full_i,
  input  logic       sup_arm_i,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  input  logic       host_oe_n,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       dq_oe,
  output logic       sel_backup,
  output logic       batt_armed,
  output logic [2:0] status
);
  logic [NUM_FLAGS-1:0] raw_flags, flt_flags;
  pfs_state_e           state;

  assign raw_flags[FL_SW]   = sup_sw_i;
  assign raw_flags[FL_FULL] = sup_full_i;
  assign raw_flags[FL_ARM]  = sup_arm_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    pfs_flag_filter #(.STABLE_CYC(STABLE_CYC)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_flags[g]),
      .flt_o (flt_flags[g])
    );
  end

  pfs_power_fsm #(.REC_CYC(REC_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .f_sw      (flt_flags[FL_SW]),
    .f_full    (flt_flags[FL_FULL]),
    .f_arm     (flt_flags[FL_ARM]),
    .host_ce_n (host_ce_n),
    .state_o   (state),
    .armed_o   (batt_armed)
  );

  pfs_access_gate u_gate (
    .state_i    (state),
    .host_ce_n  (host_ce_n),
    .host_we_n  (host_we_n),
    .host_oe_n  (host_oe_n),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .dq_oe      (dq_oe),
    .sel_backup (sel_backup)
  );

  assign status = state;
endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_ce_n,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       dq_oe,
  input logic       sel_backup,
  input logic       batt_armed,
  input logic [2:0] status
);
  // R4
  locked_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'd1) |-> (mem_ce_n && mem_we_n && !dq_oe));

  // R3
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_armed |=> batt_armed);

  // R6
  backup_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_backup |-> batt_armed);

  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 3'd4);

  // R10
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd1 && $past(status) != 3'd1) |-> ($past(status) == 3'd4));

  // R8
  quiet_host_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd1 && $past(status) == 3'd4) |-> $past(host_ce_n));

  // R6
  battery_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd3 && $past(status) != 3'd3) |-> ($past(status) == 3'd2));
endmodule

bind pfs_supervisor pfs_supervisor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ce_n  (host_ce_n),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .dq_oe      (dq_oe),
  .sel_backup (sel_backup),
  .batt_armed (batt_armed),
  .status     (status)
);

// File: tb/pfs_supervisor_test.sv
module pfs_supervisor_test;
  localparam int STB = 2;
  localparam int REC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw = 1'b0, full = 1'b0, arm = 1'b0;
  logic hce = 1'b1, hwe = 1'b1, hoe = 1'b1;
  logic mem_ce_n, mem_we_n, dq_oe, sel_backup, batt_armed;
  logic [2:0] status;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit rand_host = 1'b0;
  int unsigned lfsr = 32'h1234_5678;

  int m_s1[3], m_s2[3], m_f[3], m_run[3];
  int m_state = 0, m_armed = 0, m_rec = 0;

  always #2 clk = ~clk;

  pfs_supervisor #(.STABLE_CYC(STB), .REC_CYC(REC)) uut (
    .clk(clk), .rst_n(rst_n),
    .sup_sw_i(sw), .sup_full_i(full), .sup_arm_i(arm),
    .host_ce_n(hce), .host_we_n(hwe), .host_oe_n(hoe),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .dq_oe(dq_oe),
    .sel_backup(sel_backup), .batt_armed(batt_armed), .status(status)
  );

  // Behavioural reference model, updated on each rising edge.
  always @(posedge clk) begin
    int raw[3];
    int nxt;
    raw[0] = int'(sw); raw[1] = int'(full); raw[2] = int'(arm);
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_run[i] = 0;
      end
      m_state = 0; m_armed = 0; m_rec = 0;
    end else begin
      nxt = m_state;
      case (m_state)
        0: if (m_f[2] == 1) begin nxt = 2; m_armed = 1; end
        2: if (m_f[0] == 0) nxt = 3; else if (m_f[1] == 1) nxt = 4;
        3: if (m_f[0] == 1) nxt = 2;
        4: begin
          if (m_f[1] == 0) begin nxt = 2; m_rec = 0; end
          else if (hce == 1'b0) m_rec = 0;
          else if (m_rec == REC - 1) begin nxt = 1; m_rec = 0; end
          else m_rec = m_rec + 1;
        end
        1: if (m_f[1] == 0) nxt = 2;
        default: nxt = 0;
      endcase
      if (nxt != 4) m_rec = 0;
      m_state = nxt;
      for (int i = 0; i < 3; i++) begin
        if (m_s2[i] != m_f[i]) begin
          if (m_run[i] == STB - 1) begin m_f[i] = m_s2[i]; m_run[i] = 0; end
          else m_run[i] = m_run[i] + 1;
        end else m_run[i] = 0;
        m_s2[i] = m_s1[i];
        m_s1[i] = raw[i];
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=200000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    bit ok;
    string rq;
    ok = (m_state == 1);
    rq = ok ? "R9" : "R4";
    chk("R10 status", int'(status), m_state);
    chk("R3 armed", int'(batt_armed), m_armed);
    chk("R6 sel_backup", int'(sel_backup), (m_state == 3) ? 1 : 0);
    chk({rq, " mem_ce_n"}, int'(mem_ce_n), ok ? int'(hce) : 1);
    chk({rq, " mem_we_n"}, int'(mem_we_n), ok ? int'(hwe | hce) : 1);
    chk({rq, " dq_oe"}, int'(dq_oe), (ok && !hce && !hoe && hwe) ? 1 : 0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    if (rand_host) begin
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      hce = lfsr[16]; hwe = lfsr[18]; hoe = lfsr[20];
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_state(input int want);
    for (int i = 0; i < 40; i++) begin
      if (m_state == want) break;
      tick();
    end
  endtask

  initial begin
    ticks(3);
    // R2 reset state
    chk("R2 status", int'(status), 0);
    chk("R2 armed", int'(batt_armed), 0);
    chk("R2 sel_backup", int'(sel_backup), 0);
    chk("R2 strobes", int'({mem_ce_n, mem_we_n, dq_oe}), 3'b110);
    @(negedge clk) rst_n = 1'b1;

    // R3: unarmed with supply low, backup never selected
    rand_host = 1'b1;
    ticks(6);
    chk("R3 unarmed no backup", int'(sel_backup), 0);

    // R1: one-cycle arming pulse is rejected
    arm = 1'b1; tick(); arm = 1'b0;
    ticks(7);
    chk("R1 arm glitch", int'(status), 0);

    // R3/R8: power up with host quiet
    rand_host = 1'b0; hce = 1'b1; hwe = 1'b1; hoe = 1'b1;
    sw = 1'b1; full = 1'b1; arm = 1'b1;
    wait_state(4);
    chk("R8 in recovery", int'(status), 4);
    chk("R3 armed", int'(batt_armed), 1);
    ticks(3);
    hce = 1'b0; tick(); hce = 1'b1;
    ticks(5);
    chk("R8 restart holds recovery", int'(status), 4);
    tick();
    chk("R8 normal after window", int'(status), 1);

    // R9: traffic in normal state
    rand_host = 1'b1;
    ticks(40);

    // R1: short full-function dip ignored
    full = 1'b0; tick(); full = 1'b1;
    ticks(6);
    chk("R1 full glitch", int'(status), 1);

    // R5: write in progress is cut off
    rand_host = 1'b0; hce = 1'b0; hwe = 1'b0; hoe = 1'b1;
    tick();
    chk("R9 write strobe open", int'(mem_we_n), 0);
    full = 1'b0;
    wait_state(2);
    chk("R5 protected", int'(status), 2);
    chk("R5 write cut", int'(mem_we_n), 1);

    // R6: switchover to backup; R3 arm drop keeps latch
    rand_host = 1'b1; sw = 1'b0; arm = 1'b0;
    wait_state(3);
    chk("R6 battery", int'(status), 3);
    chk("R6 sel_backup", int'(sel_backup), 1);
    ticks(10);
    chk("R3 latch kept", int'(batt_armed), 1);

    // R7: supply back above switchover
    sw = 1'b1;
    wait_state(2);
    chk("R7 protected", int'(status), 2);
    chk("R7 main rail", int'(sel_backup), 0);

    // R8: dip during recovery returns to protected
    rand_host = 1'b0; hce = 1'b1; hwe = 1'b1; hoe = 1'b1;
    full = 1'b1;
    wait_state(4);
    ticks(1);
    full = 1'b0;
    wait_state(2);
    chk("R8 dip in recovery", int'(status), 2);
    full = 1'b1;
    wait_state(1);
    chk("R8 normal again", int'(status), 1);

    // R6 priority: both flags drop together
    full = 1'b0; sw = 1'b0;
    wait_state(3);
    chk("R6 reaches battery", int'(status), 3);
    ticks(4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule